// File: doc/BRIEF.md
# ADC Power-Mode Interface Decoder

This block is the device-side digital front end of a serial sampling converter. It watches an active-low chip-select and a serial clock, and picks the converter's power state from how many serial-clock falling edges have passed when chip-select goes back high. Only a chip-select rise that lands inside the right window can switch the part into or out of power-down. Short glitches on chip-select, and bursts of a few clocks, leave the current state as it was.

Each frame opens when chip-select falls. The block then shifts a frame word out on a serial data pin, most significant bit first. The frame word is four zero bits followed by the sample word. The frame length is the resolution plus four clocks: 16 clocks at 12 bits, 14 at 10 bits and 12 at 8 bits. The block also drives:

- an output enable for the three-state data pin;
- a flag that marks a frame carrying valid data;
- a power-down flag;
- a track/hold control;
- a one-cycle abort strobe for frames cut short.

The sample word comes from a stub input. All inputs are sampled on a fast system clock.

Top module: `adc_pwr_if`

## Requirements
- R1: After reset the outputs are: power-down 0, track 1, output enable 0, abort 0. A chip-select fall resets the edge count, starts a frame and turns on the output enable. The serial data pin then shows bit FRAME-1 of the frame word {4'b0, sample}. The frame is valid (data_valid 1) when the part was not powered down.
- R2: Each serial-clock falling edge moves the data pin to the next lower bit of the frame word. The output enable drops on falling edge number FRAME, where FRAME = RES_BITS + 4.
- R3: If chip-select rises before the 2nd falling edge, the part stays in normal mode (power-down 0).
- R4: In a normal frame, a chip-select rise after 2 to 9 falling edges sets power-down to 1 and puts track/hold into hold (track 0).
- R5: In a normal frame, a chip-select rise after 10 or more falling edges but before the frame completes keeps the part powered. It releases the data pin.
- R6: The abort strobe is a one-cycle pulse. It fires when chip-select rises on a frame that has not completed. A completed frame produces no abort.
- R7: While powered down, a chip-select fall clears the power-down flag because wake-up has started. If chip-select then rises before the 10th falling edge, the part returns to power-down.
- R8: A wake-up frame that is held past 10 or more falling edges leaves the part powered. The wake-up frame has data_valid 0, and the next frame has data_valid 1.
- R9: Track/hold equals the inverse of power-down, with one exception. In a wake-up frame, track stays 0 until the first serial-clock edge of either polarity after the chip-select fall, and then becomes 1.
- R10: The edge count saturates at FRAME. Extra clocks while chip-select stays low after a completed frame do not re-enable the data pin, and they do not cause an abort.
- R11: The output enable is low whenever chip-select has been high for two consecutive system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Serial clock |
| sample | input | RES_BITS | Conversion result stub |
| sdata | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for the three-state data pin |
| data_valid | output | 1 | The current frame carries valid data |
| pwr_dn | output | 1 | Power-down state |
| track | output | 1 | 1 = track, 0 = hold |
| abort | output | 1 | One-cycle strobe when a frame is cut short |

## Verification
The power state and the edge count are internal. A wrong value in either shows up at the ports on the system-clock cycle after the next chip-select rise. It appears as a wrong power-down level, a track level that does not match it, or a missing or extra abort pulse. A wrong wake-frame marker shows in data_valid as soon as chip-select falls. A shift or count error shows in the serial bits at the next serial-clock rising edge, or in an output enable that drops on the wrong falling edge.

// File: rtl/adc_pwr_if.sv
module adc_pwr_if #(
  parameter int RES_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic [RES_BITS-1:0] sample,
  output logic                sdata,
  output logic                sdata_oe,
  output logic                data_valid,
  output logic                pwr_dn,
  output logic                track,
  output logic                abort
);
  localparam int FRAME     = RES_BITS + 4;
  localparam int CW        = $clog2(FRAME + 1);
  localparam int ENTER_MIN = 2;
  localparam int KEEP_MIN  = 10;

  logic             cs_q, sclk_q;
  logic [CW-1:0]    cnt;
  logic [FRAME-1:0] shreg;
  logic             active, wake, pd, trk, abort_q;

  wire cs_fall   = cs_q & ~cs_n;
  wire cs_rise   = ~cs_q & cs_n;
  wire sclk_fall = sclk_q & ~sclk & ~cs_n;
  wire sclk_edge = (sclk_q ^ sclk) & ~cs_n;
  wire done      = (cnt == CW'(FRAME));
  wire pd_next   = (cnt < CW'(KEEP_MIN)) ? (wake | (cnt >= CW'(ENTER_MIN))) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      active  <= 1'b0;
      wake    <= 1'b0;
      pd      <= 1'b0;
      trk     <= 1'b1;
      abort_q <= 1'b0;
    end else begin
      cs_q    <= cs_n;
      sclk_q  <= sclk;
      abort_q <= 1'b0;
      if (cs_fall) begin
        cnt    <= '0;
        active <= 1'b1;
        wake   <= pd;
        pd     <= 1'b0;
        shreg  <= {4'b0000, sample};
      end else if (cs_rise) begin
        active  <= 1'b0;
        abort_q <= active;
        wake    <= 1'b0;
        pd      <= pd_next;
        trk     <= ~pd_next;
      end else begin
        if (sclk_fall && !done) begin
          cnt   <= cnt + 1'b1;
          shreg <= {shreg[FRAME-2:0], 1'b0};
          if (cnt == CW'(FRAME - 1)) active <= 1'b0;
        end
        if (wake && sclk_edge) trk <= 1'b1;
      end
    end
  end

  assign sdata      = shreg[FRAME-1];
  assign sdata_oe   = active;
  assign data_valid = active & ~wake;
  assign pwr_dn     = pd;
  assign track      = trk;
  assign abort      = abort_q;
endmodule

module adc_pwr_if_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdata_oe,
  input logic data_valid,
  input logic pwr_dn,
  input logic track,
  input logic abort
);
  p_abort_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  p_abort_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !sdata_oe);
  p_oe_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sdata_oe);
  p_hold_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !track);
  p_valid_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> sdata_oe);
  p_enter_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_dn) |-> $past(cs_n));
  p_wake_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_dn) |-> !$past(cs_n));
endmodule

bind adc_pwr_if adc_pwr_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdata_oe(sdata_oe),
  .data_valid(data_valid), .pwr_dn(pwr_dn), .track(track), .abort(abort)
);

// File: tb/adc_pwr_if_tb.sv
module adc_pwr_if_tb;
  localparam int RES   = 12;
  localparam int FRAME = RES + 4;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
  logic [RES-1:0] smp = '0;
  logic sdata, sdata_oe, data_valid, pwr_dn, track, abort;

  adc_pwr_if #(.RES_BITS(RES)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(smp),
    .sdata(sdata), .sdata_oe(sdata_oe), .data_valid(data_valid),
    .pwr_dn(pwr_dn), .track(track), .abort(abort)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, n_ab = 0, tb_k = 0, a0 = 0;
  logic [FRAME-1:0] word;
  bit exp_q[$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic step();
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_low(input logic [RES-1:0] s);
    smp = s; word = {4'b0000, s}; tb_k = 0;
    cs_n = 1'b0; step();
  endtask

  task automatic falls(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; step();
      tb_k++;
      if (tb_k <= FRAME - 1) exp_q.push_back(word[FRAME-1-tb_k]);
      sclk = 1'b1; step();
    end
  endtask

  task automatic cs_high();
    a0 = n_ab;
    cs_n = 1'b1; step();
  endtask

  always @(negedge clk) if (abort) n_ab++;

  always @(posedge sclk) begin
    if (sdata_oe) begin
      if (exp_q.size() == 0) chk("R2 unexpected bit", 32'(sdata), 32'h2);
      else chk("R2 serial bit", 32'(sdata), 32'(exp_q.pop_front()));
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); rst_n = 1'b1; step();
    chk("R1 reset oe", 32'(sdata_oe), 0);
    chk("R1 reset pd", 32'(pwr_dn), 0);
    chk("R1 reset track", 32'(track), 1);
    chk("R1 reset abort", 32'(abort), 0);

    cs_low(12'hA5C);
    chk("R1 oe", 32'(sdata_oe), 1);
    chk("R1 valid", 32'(data_valid), 1);
    chk("R1 first bit", 32'(sdata), 0);
    falls(FRAME);
    chk("R2 oe off at end", 32'(sdata_oe), 0);
    cs_high();
    chk("R6 no abort on complete", 32'(n_ab - a0), 0);
    chk("R6 pd", 32'(pwr_dn), 0);

    cs_low(12'h3C1); falls(1); cs_high();
    chk("R3 glitch pd", 32'(pwr_dn), 0);
    chk("R6 glitch abort", 32'(n_ab - a0), 1);

    cs_low(12'hFFF); falls(10); cs_high();
    chk("R5 pd at 10", 32'(pwr_dn), 0);
    chk("R5 oe", 32'(sdata_oe), 0);
    chk("R5 abort", 32'(n_ab - a0), 1);

    cs_low(12'h5A5); falls(12); cs_high();
    chk("R5 pd at 12", 32'(pwr_dn), 0);
    chk("R9 track", 32'(track), 1);

    cs_low(12'h123); falls(2); cs_high();
    chk("R4 pd at 2", 32'(pwr_dn), 1);
    chk("R4 hold", 32'(track), 0);

    cs_low(12'h0F0);
    chk("R7 wake starts", 32'(pwr_dn), 0);
    chk("R8 wake invalid", 32'(data_valid), 0);
    chk("R9 hold before edge", 32'(track), 0);
    falls(1);
    chk("R9 track after edge", 32'(track), 1);
    falls(5); cs_high();
    chk("R7 back to pd", 32'(pwr_dn), 1);
    chk("R9 hold again", 32'(track), 0);
    chk("R6 wake abort", 32'(n_ab - a0), 1);

    cs_low(12'h777); falls(10); cs_high();
    chk("R8 awake at 10", 32'(pwr_dn), 0);

    cs_low(12'h888); falls(9); cs_high();
    chk("R4 pd at 9", 32'(pwr_dn), 1);

    cs_low(12'h999); falls(FRAME); cs_high();
    chk("R8 awake after full dummy", 32'(pwr_dn), 0);
    chk("R9 track awake", 32'(track), 1);
    cs_low(12'hC3A);
    chk("R8 next valid", 32'(data_valid), 1);
    falls(FRAME); cs_high();

    cs_low(12'hBEE); falls(FRAME + 4);
    chk("R10 oe stays off", 32'(sdata_oe), 0);
    cs_high();
    chk("R10 no abort", 32'(n_ab - a0), 0);
    chk("R10 pd", 32'(pwr_dn), 0);
    chk("R11 oe with cs high", 32'(sdata_oe), 0);

    step();
    chk("R2 queue drained", 32'(exp_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule